// File: doc/BRIEF.md
# Transmit Gain Index Calculator

This block turns a requested transmit power for one transmit chain into an index into a half-dB gain table. A higher index means lower output power. The calculation runs as a fixed chain of seven stages, one per clock.

The first stage caps the target. The cap is the regulatory limit, lowered for multi-antenna (MIMO) rates, and the saturation level minus a back-off that depends on the rate. The later stages work in half-dB steps. They add the power error against the interpolated factory data to the factory index, correct for temperature and for supply voltage, and add the chain's balancing attenuation for MIMO rates. They then add a revision-dependent back-off for CCK rates and finally clamp to the table range of the band.

A one-cycle `start_i` pulse latches every operand while the block is idle. A one-cycle `done_o` pulse marks the result on `index_o`. That result stays valid until the next calculation finishes.

Top module: `tx_gain_index_calc`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `index_o` is 0.
- R2: `start_i` is accepted only while `busy_o` is low, and the operands are latched at that edge. `busy_o` is high for the 7 cycles that follow. `done_o` is high for exactly the one cycle after the clamp stage, which is 7 clock edges after the accepting edge. A start seen while busy is ignored, and so are operand changes made while busy. A start in the cycle where `done_o` is high is accepted.
- R3: The target is capped at the regulatory limit. When `mimo_i` is 1, the cap is the regulatory limit minus 6.
- R4: The target is also capped at saturation minus a back-off chosen by `rate_i`. The encodings are: 0 (OFDM 6 to 36 Mb/s) 10, 1 (OFDM 48) 15, 2 (OFDM 54) 17, 3 (OFDM 60) 20, and 4 (CCK) 10. MIMO does not change this cap.
- R5: The starting index is the factory index plus (factory power minus capped target). All powers are in half-dBm.
- R6: Let the temperature difference be current minus factory. The stage subtracts that difference ×2/7 on 2.4 GHz (`band5g_i`=0). On 5 GHz it subtracts the difference ×2/9 for channels below 44 and the difference /4 for channels 44 and up. Each division truncates toward zero.
- R7: Let d be the factory supply indicator minus the current one. The stage adds d/7 when d ≥ 0 and 2·d/7 when d < 0, truncating toward zero. It adds 0 instead when the magnitude of that term exceeds 2.
- R8: When `mimo_i` is 1, the stage adds the signed byte `atten_i[8g+7:8g]`. The group g is 4 for 2.4 GHz. On 5 GHz, g is 0 for channels up to 43, 1 for 44 to 70, 2 for 71 to 124 and 3 for 125 and up.
- R9: When `rate_i` is 4 (CCK), the stage adds 9 if `hw_rev_i` is 1 (revision B) and 5 if it is 2 (revision C). Any other revision value adds 0.
- R10: The result is clamped to 0..98 on 2.4 GHz and to -9..98 on 5 GHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a calculation (used only when idle) |
| target_i | input | 8 | Requested power, half-dBm |
| reg_limit_i | input | 8 | Regulatory limit, half-dBm |
| sat_limit_i | input | 8 | Saturation level, half-dBm |
| rate_i | input | 3 | Rate class, encoded as in R4 |
| mimo_i | input | 1 | Two chains transmit together |
| band5g_i | input | 1 | 1 = 5 GHz, 0 = 2.4 GHz |
| chan_i | input | 8 | Channel number |
| fac_index_i | input | 8 | Interpolated factory index, signed |
| fac_power_i | input | 8 | Interpolated factory power, half-dBm |
| fac_temp_i | input | 8 | Factory temperature, °C, signed |
| cur_temp_i | input | 8 | Current temperature, °C, signed |
| fac_volt_i | input | 8 | Factory supply indicator, signed |
| cur_volt_i | input | 8 | Current supply indicator, signed |
| atten_i | input | 40 | Five signed per-group attenuation bytes for this chain |
| hw_rev_i | input | 2 | Hardware revision, encoded as in R9 |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| index_o | output | 8 | Gain index, signed |

## Verification
Two events can share a cycle: the completion strobe of one calculation, and the arrival of the next start. The bench holds `start_i` high across the whole of a calculation and changes the operands right after the first start is taken. The early starts must be ignored, and the start present in the `done_o` cycle must launch a second calculation on the new operands. A second case pulses start and changes the operands while the block is busy, and the result must match the first operand set. A behavioural model predicts busy, done and the index on every clock, and flags any deviation in either case.

// File: rtl/tx_gain_pkg.sv
package tx_gain_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_LIMIT, ST_POWER, ST_TEMP, ST_VOLT, ST_BAL, ST_CCK, ST_CLAMP
    } stage_e;

    localparam logic [2:0] RATE_OFDM_LO = 3'd0;
    localparam logic [2:0] RATE_OFDM_48 = 3'd1;
    localparam logic [2:0] RATE_OFDM_54 = 3'd2;
    localparam logic [2:0] RATE_OFDM_60 = 3'd3;
    localparam logic [2:0] RATE_CCK     = 3'd4;

    localparam logic [1:0] REV_B = 2'd1;
    localparam logic [1:0] REV_C = 2'd2;
endpackage

// File: rtl/tx_gain_limit.sv
module tx_gain_limit
    import tx_gain_pkg::*;
#(
    parameter int VW        = 8,
    parameter int AW        = 12,
    parameter int MIMO_CUT  = 6,
    parameter int BO_LO     = 10,
    parameter int BO_48     = 15,
    parameter int BO_54     = 17,
    parameter int BO_60     = 20,
    parameter int BO_CCK    = 10
) (
    input  logic [VW-1:0]        target_i,
    input  logic [VW-1:0]        reg_i,
    input  logic [VW-1:0]        sat_i,
    input  logic [2:0]           rate_i,
    input  logic                 mimo_i,
    output logic signed [AW-1:0] tgt_o
);
    logic signed [AW-1:0] backoff, reg_cap, sat_cap, want;

    always_comb begin
        case (rate_i)
            RATE_OFDM_48: backoff = AW'(BO_48);
            RATE_OFDM_54: backoff = AW'(BO_54);
            RATE_OFDM_60: backoff = AW'(BO_60);
            RATE_CCK:     backoff = AW'(BO_CCK);
            default:      backoff = AW'(BO_LO);
        endcase
        want    = AW'(target_i);
        reg_cap = AW'(reg_i) - (mimo_i ? AW'(MIMO_CUT) : '0);
        sat_cap = AW'(sat_i) - backoff;
        tgt_o   = want;
        if (reg_cap < tgt_o) tgt_o = reg_cap;
        if (sat_cap < tgt_o) tgt_o = sat_cap;
    end
endmodule

// File: rtl/tx_gain_temp_step.sv
module tx_gain_temp_step #(
    parameter int VW       = 8,
    parameter int AW       = 12,
    parameter int CH_SPLIT = 44
) (
    input  logic                 band5g_i,
    input  logic [VW-1:0]        chan_i,
    input  logic signed [VW-1:0] cur_i,
    input  logic signed [VW-1:0] fac_i,
    output logic signed [AW-1:0] step_o
);
    localparam logic signed [AW-1:0] K4 = 4;
    localparam logic signed [AW-1:0] K7 = 7;
    localparam logic signed [AW-1:0] K9 = 9;

    logic signed [AW-1:0] diff, dbl;

    always_comb begin
        diff = AW'(cur_i) - AW'(fac_i);
        dbl  = diff <<< 1;
        if (!band5g_i)                    step_o = dbl / K7;
        else if (chan_i < VW'(CH_SPLIT))  step_o = dbl / K9;
        else                              step_o = diff / K4;
    end
endmodule

// File: rtl/tx_gain_volt_step.sv
module tx_gain_volt_step #(
    parameter int VW = 8,
    parameter int AW = 12
) (
    input  logic signed [VW-1:0] cur_i,
    input  logic signed [VW-1:0] fac_i,
    output logic signed [AW-1:0] step_o
);
    localparam logic signed [AW-1:0] K2 = 2;
    localparam logic signed [AW-1:0] K7 = 7;

    logic signed [AW-1:0] diff, raw;

    always_comb begin
        diff = AW'(fac_i) - AW'(cur_i);
        raw  = (diff >= 0) ? diff / K7 : (diff <<< 1) / K7;
        step_o = (raw > K2 || raw < -K2) ? '0 : raw;
    end
endmodule

// File: rtl/tx_gain_group.sv
module tx_gain_group #(
    parameter int VW      = 8,
    parameter int NGRP    = 5,
    parameter int G0_LAST = 43,
    parameter int G1_LAST = 70,
    parameter int G2_LAST = 124,
    localparam int GW     = $clog2(NGRP)
) (
    input  logic          band5g_i,
    input  logic [VW-1:0] chan_i,
    output logic [GW-1:0] grp_o
);
    always_comb begin
        if (!band5g_i)                  grp_o = GW'(NGRP - 1);
        else if (chan_i <= VW'(G0_LAST)) grp_o = GW'(0);
        else if (chan_i <= VW'(G1_LAST)) grp_o = GW'(1);
        else if (chan_i <= VW'(G2_LAST)) grp_o = GW'(2);
        else                             grp_o = GW'(3);
    end
endmodule

// File: rtl/tx_gain_index_calc.sv
module tx_gain_index_calc
    import tx_gain_pkg::*;
#(
    parameter int VW         = 8,
    parameter int AW         = 12,
    parameter int NGRP       = 5,
    parameter int IDX_MAX    = 98,
    parameter int IDX_MIN_2G = 0,
    parameter int IDX_MIN_5G = -9,
    parameter int MIMO_CUT   = 6,
    parameter int CCK_BO_B   = 9,
    parameter int CCK_BO_C   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [VW-1:0]        target_i,
    input  logic [VW-1:0]        reg_limit_i,
    input  logic [VW-1:0]        sat_limit_i,
    input  logic [2:0]           rate_i,
    input  logic                 mimo_i,
    input  logic                 band5g_i,
    input  logic [VW-1:0]        chan_i,
    input  logic signed [VW-1:0] fac_index_i,
    input  logic [VW-1:0]        fac_power_i,
    input  logic signed [VW-1:0] fac_temp_i,
    input  logic signed [VW-1:0] cur_temp_i,
    input  logic signed [VW-1:0] fac_volt_i,
    input  logic signed [VW-1:0] cur_volt_i,
    input  logic [NGRP*VW-1:0]   atten_i,
    input  logic [1:0]           hw_rev_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic signed [VW-1:0] index_o
);
    localparam int GW = $clog2(NGRP);
    localparam logic signed [AW-1:0] MAX_A   = AW'(IDX_MAX);
    localparam logic signed [AW-1:0] MIN2G_A = AW'(IDX_MIN_2G);
    localparam logic signed [AW-1:0] MIN5G_A = AW'(IDX_MIN_5G);

    typedef struct packed {
        logic                 band5g;
        logic                 mimo;
        logic [2:0]           rate;
        logic [1:0]           rev;
        logic [VW-1:0]        chan;
        logic [VW-1:0]        target;
        logic [VW-1:0]        regl;
        logic [VW-1:0]        sat;
        logic [VW-1:0]        fpow;
        logic signed [VW-1:0] fidx;
        logic signed [VW-1:0] ftemp;
        logic signed [VW-1:0] ctemp;
        logic signed [VW-1:0] fvolt;
        logic signed [VW-1:0] cvolt;
        logic [NGRP*VW-1:0]   atten;
    } opnd_t;

    typedef struct packed {
        stage_e               st;
        opnd_t                op;
        logic signed [AW-1:0] tgt;
        logic signed [AW-1:0] idx;
        logic                 done;
    } regs_t;

    regs_t r_d, r_q;

    logic signed [AW-1:0] lim_tgt, temp_step, volt_step, bal_add, low_bound;
    logic [GW-1:0]        grp;

    tx_gain_limit #(.VW(VW), .AW(AW), .MIMO_CUT(MIMO_CUT)) i_limit (
        .target_i (r_q.op.target),
        .reg_i    (r_q.op.regl),
        .sat_i    (r_q.op.sat),
        .rate_i   (r_q.op.rate),
        .mimo_i   (r_q.op.mimo),
        .tgt_o    (lim_tgt)
    );

    tx_gain_temp_step #(.VW(VW), .AW(AW)) i_temp (
        .band5g_i (r_q.op.band5g),
        .chan_i   (r_q.op.chan),
        .cur_i    (r_q.op.ctemp),
        .fac_i    (r_q.op.ftemp),
        .step_o   (temp_step)
    );

    tx_gain_volt_step #(.VW(VW), .AW(AW)) i_volt (
        .cur_i  (r_q.op.cvolt),
        .fac_i  (r_q.op.fvolt),
        .step_o (volt_step)
    );

    tx_gain_group #(.VW(VW), .NGRP(NGRP)) i_group (
        .band5g_i (r_q.op.band5g),
        .chan_i   (r_q.op.chan),
        .grp_o    (grp)
    );

    always_comb begin
        bal_add   = AW'($signed(r_q.op.atten[int'(grp)*VW +: VW]));
        low_bound = r_q.op.band5g ? MIN5G_A : MIN2G_A;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.op.band5g = band5g_i;
                    r_d.op.mimo   = mimo_i;
                    r_d.op.rate   = rate_i;
                    r_d.op.rev    = hw_rev_i;
                    r_d.op.chan   = chan_i;
                    r_d.op.target = target_i;
                    r_d.op.regl   = reg_limit_i;
                    r_d.op.sat    = sat_limit_i;
                    r_d.op.fpow   = fac_power_i;
                    r_d.op.fidx   = fac_index_i;
                    r_d.op.ftemp  = fac_temp_i;
                    r_d.op.ctemp  = cur_temp_i;
                    r_d.op.fvolt  = fac_volt_i;
                    r_d.op.cvolt  = cur_volt_i;
                    r_d.op.atten  = atten_i;
                    r_d.st        = ST_LIMIT;
                end
            end
            ST_LIMIT: begin
                r_d.tgt = lim_tgt;
                r_d.st  = ST_POWER;
            end
            ST_POWER: begin
                r_d.idx = AW'(r_q.op.fidx) + AW'(r_q.op.fpow) - r_q.tgt;
                r_d.st  = ST_TEMP;
            end
            ST_TEMP: begin
                r_d.idx = r_q.idx - temp_step;
                r_d.st  = ST_VOLT;
            end
            ST_VOLT: begin
                r_d.idx = r_q.idx + volt_step;
                r_d.st  = ST_BAL;
            end
            ST_BAL: begin
                if (r_q.op.mimo) r_d.idx = r_q.idx + bal_add;
                r_d.st = ST_CCK;
            end
            ST_CCK: begin
                if (r_q.op.rate == RATE_CCK) begin
                    if (r_q.op.rev == REV_B)      r_d.idx = r_q.idx + AW'(CCK_BO_B);
                    else if (r_q.op.rev == REV_C) r_d.idx = r_q.idx + AW'(CCK_BO_C);
                end
                r_d.st = ST_CLAMP;
            end
            ST_CLAMP: begin
                if (r_q.idx > MAX_A)          r_d.idx = MAX_A;
                else if (r_q.idx < low_bound) r_d.idx = low_bound;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = (r_q.st != ST_IDLE);
    assign done_o  = r_q.done;
    assign index_o = r_q.idx[VW-1:0];

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_DONE_AFTER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CLAMP) |=> (done_o && !busy_o)); // R2
    AST_OPND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(r_q.op)); // R2
    AST_REG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POWER) |->
        (r_q.tgt <= AW'(r_q.op.regl) - (r_q.op.mimo ? AW'(MIMO_CUT) : '0))); // R3
    AST_TEMP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TEMP && r_q.op.ctemp > r_q.op.ftemp) |-> (temp_step >= 0)); // R6
    AST_VOLT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_VOLT) |-> (volt_step <= 2 && volt_step >= -2)); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (r_q.idx <= MAX_A && r_q.idx >= low_bound)); // R10
endmodule

// File: tb/test_tx_gain_index_calc.sv
`timescale 1ns/1ps
module test_tx_gain_index_calc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              start = 1'b0;
    logic [7:0]        target, regl, sat, fpow, chan;
    logic [2:0]        rate;
    logic              mimo, band5g;
    logic signed [7:0] fidx, ftemp, ctemp, fvolt, cvolt;
    logic signed [7:0] att [5];
    logic [1:0]        rev;
    logic [39:0]       atten;
    logic              busy, done;
    logic signed [7:0] index;

    assign atten = {att[4], att[3], att[2], att[1], att[0]};

    tx_gain_index_calc i_tx_gain_index_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .target_i(target), .reg_limit_i(regl), .sat_limit_i(sat),
        .rate_i(rate), .mimo_i(mimo), .band5g_i(band5g), .chan_i(chan),
        .fac_index_i(fidx), .fac_power_i(fpow), .fac_temp_i(ftemp),
        .cur_temp_i(ctemp), .fac_volt_i(fvolt), .cur_volt_i(cvolt),
        .atten_i(atten), .hw_rev_i(rev),
        .busy_o(busy), .done_o(done), .index_o(index)
    );

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    finished = 0;
    string cur_tag = "R5";

    int    mcnt = 0;
    bit    mdone = 0;
    int    m_exp = 0;
    string m_tag = "";

    function automatic int ref_idx();
        int rl, bo, t, idx, d, ts, vd, vs, g;
        rl = int'(regl) - (mimo ? 6 : 0);
        case (rate)
            3'd1: bo = 15;
            3'd2: bo = 17;
            3'd3: bo = 20;
            default: bo = 10;
        endcase
        t = int'(target);
        if (rl < t) t = rl;
        if (int'(sat) - bo < t) t = int'(sat) - bo;
        idx = int'(fidx) + int'(fpow) - t;
        d = int'(ctemp) - int'(ftemp);
        if (!band5g)         ts = (d * 10) / 35;
        else if (chan < 44)  ts = (d * 10) / 45;
        else                 ts = (d * 10) / 40;
        idx -= ts;
        vd = int'(fvolt) - int'(cvolt);
        if (vd >= 0) vs = vd / 7;
        else         vs = -((-vd * 2) / 7);
        if (vs > 2 || vs < -2) vs = 0;
        idx += vs;
        if (mimo) begin
            if (!band5g)          g = 4;
            else if (chan <= 43)  g = 0;
            else if (chan <= 70)  g = 1;
            else if (chan <= 124) g = 2;
            else                  g = 3;
            idx += int'(att[g]);
        end
        if (rate == 3'd4) begin
            if (rev == 2'd1)      idx += 9;
            else if (rev == 2'd2) idx += 5;
        end
        if (idx > 98) idx = 98;
        if (idx < (band5g ? -9 : 0)) idx = band5g ? -9 : 0;
        return idx;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            mcnt = 0;
            mdone = 0;
        end else begin
            mdone = (mcnt == 1);
            if (mcnt != 0) mcnt--;
            else if (start) begin
                mcnt = 7;
                m_exp = ref_idx();
                m_tag = cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (busy !== (mcnt != 0) || done !== mdone) begin
                fails++;
                $display("FAIL R2 (%s): busy=%0b done=%0b expected busy=%0b done=%0b",
                         m_tag, busy, done, mcnt != 0, mdone);
            end
            if (mdone) begin
                checks++;
                if (int'(index) != m_exp) begin
                    fails++;
                    $display("FAIL %s: index=%0d expected %0d", m_tag, index, m_exp);
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic base();
        target = 8'd30; regl = 8'd40; sat = 8'd60; fpow = 8'd30; chan = 8'd6;
        rate = 3'd0; mimo = 1'b0; band5g = 1'b0; fidx = 8'sd40;
        ftemp = 8'sd25; ctemp = 8'sd25; fvolt = 8'sd100; cvolt = 8'sd100;
        for (int g = 0; g < 5; g++) att[g] = 8'sd0;
        rev = 2'd1;
    endtask

    task automatic go(input string tag);
        @(negedge clk);
        cur_tag = tag;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        base();
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || index !== 8'sd0) begin
            fails++;
            $display("FAIL R1: busy=%0b done=%0b index=%0d expected 0 0 0", busy, done, index);
        end
        rst_n = 1'b1;

        // R5: power error
        base(); go("R5");
        base(); fpow = 8'd36; target = 8'd30; go("R5");
        base(); fpow = 8'd20; go("R5");

        // R3: regulatory cap, with and without MIMO
        base(); target = 8'd50; regl = 8'd40; sat = 8'd100; go("R3");
        base(); target = 8'd50; regl = 8'd40; sat = 8'd100; mimo = 1'b1; chan = 8'd1; go("R3");

        // R4: saturation back-off per rate class
        for (int r = 0; r < 5; r++) begin
            base(); target = 8'd80; regl = 8'd90; sat = 8'd60; rate = 3'(r); rev = 2'd0; go("R4");
        end
        base(); target = 8'd80; regl = 8'd90; sat = 8'd60; mimo = 1'b1; go("R4");

        // R6: temperature on each band case
        for (int k = 0; k < 3; k++) begin
            base();
            band5g = (k != 0);
            chan = (k == 1) ? 8'd36 : (k == 2) ? 8'd100 : 8'd6;
            ctemp = 8'sd39; go("R6");
            base();
            band5g = (k != 0);
            chan = (k == 1) ? 8'd36 : (k == 2) ? 8'd100 : 8'd6;
            ctemp = 8'sd11; go("R6");
        end

        // R7: voltage steps and cut-off
        base(); cvolt = 8'sd86; go("R7");
        base(); cvolt = 8'sd79; go("R7");
        base(); cvolt = 8'sd107; go("R7");
        base(); cvolt = 8'sd111; go("R7");
        base(); cvolt = 8'sd104; go("R7");

        // R8: balancing attenuation per group
        for (int g = 0; g < 5; g++) begin
            base(); mimo = 1'b1; target = 8'd20;
            for (int j = 0; j < 5; j++) att[j] = 8'(j + 1);
            band5g = (g != 4);
            chan = (g == 0) ? 8'd40 : (g == 1) ? 8'd60 : (g == 2) ? 8'd100 :
                   (g == 3) ? 8'd150 : 8'd11;
            go("R8");
        end
        base(); target = 8'd20; att[4] = 8'sd7; go("R8");

        // R9: CCK back-off per revision
        for (int v = 0; v < 4; v++) begin
            base(); rate = 3'd4; rev = 2'(v); go("R9");
        end
        base(); rate = 3'd3; rev = 2'd1; go("R9");

        // R10: clamps
        base(); fidx = 8'sd2; fpow = 8'd10; go("R10");
        base(); band5g = 1'b1; chan = 8'd100; fidx = 8'sd2; fpow = 8'd10; go("R10");
        base(); band5g = 1'b1; chan = 8'd100; fidx = 8'sd120; fpow = 8'd60; go("R10");

        // R2: start and operand change while busy are ignored
        base();
        @(negedge clk); cur_tag = "R2"; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); target = 8'd5; fidx = 8'sd10; start = 1'b1;
        repeat (2) @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);

        // R2: start held through done launches a second run
        base();
        @(negedge clk); cur_tag = "R2"; start = 1'b1;
        @(negedge clk); fidx = 8'sd70; ctemp = 8'sd60;
        repeat (8) @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);

        // mixed operands
        for (int n = 0; n < 300; n++) begin
            target = 8'($urandom_range(0, 120));
            regl = 8'($urandom_range(10, 120));
            sat = 8'($urandom_range(20, 140));
            fpow = 8'($urandom_range(0, 120));
            fidx = 8'($urandom_range(0, 100));
            rate = 3'($urandom_range(0, 4));
            mimo = 1'($urandom_range(0, 1));
            band5g = 1'($urandom_range(0, 1));
            chan = band5g ? 8'($urandom_range(34, 200)) : 8'($urandom_range(1, 14));
            ftemp = 8'(int'($urandom_range(0, 100)) - 20);
            ctemp = 8'(int'($urandom_range(0, 120)) - 20);
            fvolt = 8'($urandom_range(80, 120));
            cvolt = 8'($urandom_range(80, 120));
            for (int j = 0; j < 5; j++) att[j] = 8'($urandom_range(0, 12));
            rev = 2'($urandom_range(0, 3));
            go("R10");
        end

        finish_run();
    end
endmodule